// File: doc/BRIEF.md
# Multi-Queue FIFO Controller

This block carves one shared word store into up to eight logical FIFO queues, each with its own depth. A single write port and a single read port each carry a queue-select address. On any cycle the write side may push into one queue while the read side pops from the same queue or from another one. Each side can complete one transfer per cycle.

The read side works as first-word-fall-through. The head word of the queue chosen on `rd_sel` is presented, already fetched, on `rd_data` one cycle later, and `rd_valid` qualifies it. The write side reports `full` for the queue named on `wr_sel`. Two status buses give an almost-empty bit and an almost-full bit for every queue at all times, whether or not that queue is selected.

The queue count, the per-queue depths in blocks of `BLK_WORDS` words, and the per-queue flag offsets are captured while `rst_n` is low and frozen after it rises. A default setting gives eight equal queues. A partial reset empties one queue when both ports point at it.

Top module: `mq_fifo`

## Requirements
- R1: Queue count (`cfg_nq`, clamped to 1..NUM_Q), per-queue block counts (`cfg_blks`, 4 bits per queue, queue i at bits [4i+3:4i], depth = blocks x 256 words) and flag offsets (12 bits per queue, queue i at bits [12i+11:12i]) are captured during master reset. Changing these pins afterwards has no effect.
- R2: When `cfg_dflt` is high during master reset, all NUM_Q queues are active, each with TOTAL_BLKS/NUM_Q blocks, and both flag offsets are 16 for every queue.
- R3: `full` is 1 when the queue on `wr_sel` holds as many words as its depth, or when its index is not below the active count. A write (`wr_en`) to such a queue is dropped. Otherwise the word is appended to that queue.
- R4: `rd_data`/`rd_valid` show the head of the queue that `rd_sel` named on the previous cycle. `rd_en` with `rd_valid` high pops that word. `rd_en` with `rd_valid` low is ignored.
- R5: A word written into an empty queue that is selected for reading appears with `rd_valid` high on the cycle after the write.
- R6: Words leave each queue in the order they entered. A write and a read may complete in the same cycle, on the same queue or on different queues.
- R7: `ae_bus[i]` is 1 when queue i holds no more words than its almost-empty offset. It is also 1 for an inactive queue.
- R8: `af_bus[i]` is 1 when the occupancy of queue i plus its almost-full offset is at least its depth. It is 0 for an inactive queue.
- R9: With `prst` high and `wr_sel` equal to `rd_sel`, that queue is emptied and no write or read completes that cycle. With `prst` high and the selects different, `prst` has no effect.
- R10: Each queue's storage wraps, so a full queue drained to empty accepts and returns further words in order.
- R11: After master reset every queue is empty and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset; configuration captured while low |
| cfg_dflt | input | 1 | Select the built-in equal-queue setting at master reset |
| cfg_nq | input | QW+1 | Number of active queues |
| cfg_blks | input | NUM_Q*BCW | Per-queue block counts |
| cfg_ae_off | input | NUM_Q*CW | Per-queue almost-empty offsets |
| cfg_af_off | input | NUM_Q*CW | Per-queue almost-full offsets |
| wr_en | input | 1 | Write request |
| wr_sel | input | QW | Queue addressed by the write port |
| wr_data | input | DW | Write word |
| full | output | 1 | Write-selected queue cannot accept a word |
| rd_en | input | 1 | Pop the presented word |
| rd_sel | input | QW | Queue addressed by the read port |
| rd_data | output | DW | Head word of the read-selected queue |
| rd_valid | output | 1 | `rd_data` holds a real word |
| prst | input | 1 | Partial reset of the queue selected on both ports |
| ae_bus | output | NUM_Q | Almost-empty bit per queue |
| af_bus | output | NUM_Q | Almost-full bit per queue |

## Verification
The bench writes into a queue that is empty while it is selected for reading. A design that fetches the head from the store without bypassing the word being written would present stale data with `rd_valid` set. It fills a queue to its limit, pushes one extra word, drains it fully and refills across the wrap point. An off-by-one full test or a missing wrap would either lose the extra word's rejection or scramble the order. Partial reset is driven once with matching selects and once with different ones, which catches a design that clears the wrong queue or ignores the select condition. A second master reset with the default setting, followed by repeated writes into queue 7, checks that the equal split and the default offsets take effect, and that late changes to the configuration pins are ignored.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
    localparam int MQF_NUM_Q      = 8;
    localparam int MQF_DW         = 36;
    localparam int MQF_BLK_WORDS  = 256;
    localparam int MQF_TOTAL_BLKS = 8;
    localparam int MQF_DEF_OFF    = 16;

    typedef enum logic {
        SRC_PINS    = 1'b0,
        SRC_DEFAULT = 1'b1
    } cfg_src_e;
endpackage

// File: rtl/mqf_cfg.sv
module mqf_cfg
    import mqf_pkg::*;
#(
    parameter int NUM_Q      = MQF_NUM_Q,
    parameter int BLK_WORDS  = MQF_BLK_WORDS,
    parameter int TOTAL_BLKS = MQF_TOTAL_BLKS,
    parameter int DEF_OFF    = MQF_DEF_OFF,
    localparam int TOTAL_WORDS = BLK_WORDS * TOTAL_BLKS,
    localparam int CW  = $clog2(TOTAL_WORDS + 1),
    localparam int QW  = $clog2(NUM_Q),
    localparam int BCW = $clog2(TOTAL_BLKS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_dflt,
    input  logic [QW:0]                cfg_nq,
    input  logic [NUM_Q*BCW-1:0]       cfg_blks,
    input  logic [NUM_Q*CW-1:0]        cfg_ae_off,
    input  logic [NUM_Q*CW-1:0]        cfg_af_off,
    output logic [NUM_Q-1:0]           active,
    output logic [NUM_Q-1:0][CW-1:0]   depth,
    output logic [NUM_Q-1:0][CW-1:0]   base,
    output logic [NUM_Q-1:0][CW-1:0]   ae_off,
    output logic [NUM_Q-1:0][CW-1:0]   af_off
);
    typedef struct packed {
        logic [QW:0]                nq;
        logic [NUM_Q-1:0][BCW-1:0]  blks;
        logic [NUM_Q-1:0][CW-1:0]   aeo;
        logic [NUM_Q-1:0][CW-1:0]   afo;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    cfg_src_e src;

    assign src = cfg_dflt ? SRC_DEFAULT : SRC_PINS;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            case (src)
                SRC_DEFAULT: begin
                    cfg_d.nq = (QW+1)'(NUM_Q);
                    for (int i = 0; i < NUM_Q; i++) begin
                        cfg_d.blks[i] = BCW'(TOTAL_BLKS / NUM_Q);
                        cfg_d.aeo[i]  = CW'(DEF_OFF);
                        cfg_d.afo[i]  = CW'(DEF_OFF);
                    end
                end
                default: begin
                    if (cfg_nq == '0)
                        cfg_d.nq = (QW+1)'(1);
                    else if (cfg_nq > (QW+1)'(NUM_Q))
                        cfg_d.nq = (QW+1)'(NUM_Q);
                    else
                        cfg_d.nq = cfg_nq;
                    for (int i = 0; i < NUM_Q; i++) begin
                        cfg_d.blks[i] = cfg_blks[i*BCW +: BCW];
                        cfg_d.aeo[i]  = cfg_ae_off[i*CW +: CW];
                        cfg_d.afo[i]  = cfg_af_off[i*CW +: CW];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    // Queue regions are laid out back to back in queue order.
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            active[i] = ((QW+1)'(i) < cfg_q.nq);
            depth[i]  = active[i] ? CW'(32'(cfg_q.blks[i]) * BLK_WORDS) : '0;
            base[i]   = acc;
            acc       = acc + depth[i];
        end
    end

    assign ae_off = cfg_q.aeo;
    assign af_off = cfg_q.afo;

    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_q));
endmodule

// File: rtl/mqf_flags.sv
module mqf_flags #(
    parameter int NUM_Q = 8,
    parameter int CW    = 12
) (
    input  logic [NUM_Q-1:0]          active,
    input  logic [NUM_Q-1:0][CW-1:0]  cnt,
    input  logic [NUM_Q-1:0][CW-1:0]  depth,
    input  logic [NUM_Q-1:0][CW-1:0]  ae_off,
    input  logic [NUM_Q-1:0][CW-1:0]  af_off,
    output logic [NUM_Q-1:0]          ae,
    output logic [NUM_Q-1:0]          af
);
    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_flag
        logic [CW:0] fill_plus_off;
        assign fill_plus_off = {1'b0, cnt[gi]} + {1'b0, af_off[gi]};
        assign ae[gi] = !active[gi] || (cnt[gi] <= ae_off[gi]);
        assign af[gi] = active[gi] && (fill_plus_off >= {1'b0, depth[gi]});
    end
endmodule

// File: rtl/mqf_store.sv
module mqf_store #(
    parameter int DW    = 36,
    parameter int WORDS = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // A word landing on the slot being fetched is forwarded directly.
    assign rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mqf_pkg::*;
#(
    parameter int NUM_Q      = MQF_NUM_Q,
    parameter int DW         = MQF_DW,
    parameter int BLK_WORDS  = MQF_BLK_WORDS,
    parameter int TOTAL_BLKS = MQF_TOTAL_BLKS,
    parameter int DEF_OFF    = MQF_DEF_OFF,
    localparam int TOTAL_WORDS = BLK_WORDS * TOTAL_BLKS,
    localparam int AW  = $clog2(TOTAL_WORDS),
    localparam int CW  = $clog2(TOTAL_WORDS + 1),
    localparam int QW  = $clog2(NUM_Q),
    localparam int BCW = $clog2(TOTAL_BLKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_dflt,
    input  logic [QW:0]           cfg_nq,
    input  logic [NUM_Q*BCW-1:0]  cfg_blks,
    input  logic [NUM_Q*CW-1:0]   cfg_ae_off,
    input  logic [NUM_Q*CW-1:0]   cfg_af_off,
    input  logic                  wr_en,
    input  logic [QW-1:0]         wr_sel,
    input  logic [DW-1:0]         wr_data,
    output logic                  full,
    input  logic                  rd_en,
    input  logic [QW-1:0]         rd_sel,
    output logic [DW-1:0]         rd_data,
    output logic                  rd_valid,
    input  logic                  prst,
    output logic [NUM_Q-1:0]      ae_bus,
    output logic [NUM_Q-1:0]      af_bus
);
    typedef struct packed {
        logic [NUM_Q-1:0][AW-1:0] wptr;
        logic [NUM_Q-1:0][AW-1:0] rptr;
        logic [NUM_Q-1:0][CW-1:0] cnt;
        logic [QW-1:0]            rsel;
        logic                     ov;
    } state_t;

    state_t st_d, st_q;
    logic [DW-1:0] dout_q;

    logic [NUM_Q-1:0]          active;
    logic [NUM_Q-1:0][CW-1:0]  depth, base, ae_off, af_off;
    logic                      prst_hit, wsel_full, wr_go, rd_go;
    logic [AW-1:0]             waddr, raddr;
    logic [DW-1:0]             rdata;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] d);
        if (CW'(p) + CW'(1) >= d) return '0;
        return p + AW'(1);
    endfunction

    mqf_cfg #(
        .NUM_Q(NUM_Q), .BLK_WORDS(BLK_WORDS), .TOTAL_BLKS(TOTAL_BLKS), .DEF_OFF(DEF_OFF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_dflt(cfg_dflt), .cfg_nq(cfg_nq),
        .cfg_blks(cfg_blks), .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off),
        .active(active), .depth(depth), .base(base), .ae_off(ae_off), .af_off(af_off)
    );

    mqf_store #(.DW(DW), .WORDS(TOTAL_WORDS), .AW(AW)) u_store (
        .clk(clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rdata)
    );

    mqf_flags #(.NUM_Q(NUM_Q), .CW(CW)) u_flags (
        .active(active), .cnt(st_q.cnt), .depth(depth),
        .ae_off(ae_off), .af_off(af_off), .ae(ae_bus), .af(af_bus)
    );

    always_comb begin
        st_d      = st_q;
        prst_hit  = prst && (wr_sel == rd_sel);
        wsel_full = !active[wr_sel] || (st_q.cnt[wr_sel] == depth[wr_sel]);
        wr_go     = wr_en && !wsel_full && !prst_hit;
        rd_go     = rd_en && st_q.ov && !prst_hit;

        if (wr_go) st_d.wptr[wr_sel] = bump(st_q.wptr[wr_sel], depth[wr_sel]);
        if (rd_go) st_d.rptr[st_q.rsel] = bump(st_q.rptr[st_q.rsel], depth[st_q.rsel]);

        for (int i = 0; i < NUM_Q; i++) begin
            logic inc, dec;
            inc = wr_go && (wr_sel == QW'(i));
            dec = rd_go && (st_q.rsel == QW'(i));
            if (inc && !dec)      st_d.cnt[i] = st_q.cnt[i] + CW'(1);
            else if (dec && !inc) st_d.cnt[i] = st_q.cnt[i] - CW'(1);
        end

        if (prst_hit) begin
            st_d.wptr[wr_sel] = '0;
            st_d.rptr[wr_sel] = '0;
            st_d.cnt[wr_sel]  = '0;
        end

        waddr     = AW'(base[wr_sel] + CW'(st_q.wptr[wr_sel]));
        raddr     = AW'(base[rd_sel] + CW'(st_d.rptr[rd_sel]));
        st_d.rsel = rd_sel;
        st_d.ov   = (st_d.cnt[rd_sel] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            dout_q <= '0;
        end else begin
            st_q   <= st_d;
            dout_q <= rdata;
        end
    end

    assign full     = wsel_full;
    assign rd_valid = st_q.ov;
    assign rd_data  = dout_q;

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_chk
        assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[gi] <= depth[gi]);
    end

    assert_valid_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (st_q.cnt[st_q.rsel] != '0));

    assert_fwft_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en && !prst && (rd_sel == st_q.rsel)) |=> (rd_valid && $stable(rd_data)));

    assert_empty_ae_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> ae_bus[st_q.rsel]);

    assert_full_af_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && active[wr_sel]) |-> af_bus[wr_sel]);

    assert_prst_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prst && (wr_sel == rd_sel)) |=> !rd_valid);
endmodule

// File: tb/mq_fifo_test.sv
`timescale 1ns/1ps
module mq_fifo_test;
    localparam int NQ = 8, QW = 3, BCW = 4, CW = 12, DW = 36, VW = 82, NV = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cfg_dflt = 1'b0;
    logic [QW:0] cfg_nq = '0;
    logic [NQ*BCW-1:0] cfg_blks = '0;
    logic [NQ*CW-1:0] cfg_ae_off = '0, cfg_af_off = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, prst = 1'b0;
    logic [QW-1:0] wr_sel = '0, rd_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic full, rd_valid;
    logic [DW-1:0] rd_data;
    logic [NQ-1:0] ae_bus, af_bus;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mq_fifo uut (
        .clk(clk), .rst_n(rst_n), .cfg_dflt(cfg_dflt), .cfg_nq(cfg_nq),
        .cfg_blks(cfg_blks), .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
        .prst(prst), .ae_bus(ae_bus), .af_bus(af_bus)
    );

    // {we, ws, wd, re, rs, exp_valid, exp_data, exp_full}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 3'd0, 36'h0A1, 1'b0, 3'd0, 1'b1, 36'h0A1, 1'b0},
        {1'b1, 3'd0, 36'h0A2, 1'b0, 3'd1, 1'b0, 36'h000, 1'b0},
        {1'b1, 3'd1, 36'h0B1, 1'b0, 3'd1, 1'b1, 36'h0B1, 1'b0},
        {1'b0, 3'd0, 36'h000, 1'b1, 3'd0, 1'b1, 36'h0A1, 1'b0},
        {1'b0, 3'd0, 36'h000, 1'b1, 3'd0, 1'b1, 36'h0A2, 1'b0},
        {1'b1, 3'd0, 36'h0A3, 1'b1, 3'd0, 1'b1, 36'h0A3, 1'b0},
        {1'b0, 3'd0, 36'h000, 1'b1, 3'd0, 1'b0, 36'h000, 1'b0},
        {1'b1, 3'd0, 36'h0A4, 1'b1, 3'd0, 1'b1, 36'h0A4, 1'b0},
        {1'b1, 3'd2, 36'h0C1, 1'b0, 3'd2, 1'b1, 36'h0C1, 1'b0},
        {1'b1, 3'd2, 36'h0C2, 1'b1, 3'd2, 1'b1, 36'h0C2, 1'b0},
        {1'b0, 3'd2, 36'h000, 1'b1, 3'd2, 1'b0, 36'h000, 1'b0},
        {1'b1, 3'd3, 36'h0D1, 1'b0, 3'd3, 1'b0, 36'h000, 1'b1},
        {1'b0, 3'd0, 36'h000, 1'b0, 3'd0, 1'b1, 36'h0A4, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [QW-1:0] q, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = q; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // pin configuration: 3 queues of 1,1,2 blocks
        cfg_nq = 4'd3;
        cfg_blks[0*BCW +: BCW] = 4'd1;
        cfg_blks[1*BCW +: BCW] = 4'd1;
        cfg_blks[2*BCW +: BCW] = 4'd2;
        cfg_ae_off[0*CW +: CW] = 12'd1;
        cfg_ae_off[1*CW +: CW] = 12'd2;
        cfg_ae_off[2*CW +: CW] = 12'd0;
        cfg_af_off[0*CW +: CW] = 12'd1;
        cfg_af_off[1*CW +: CW] = 12'd4;
        cfg_af_off[2*CW +: CW] = 12'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        chk("R11 rd_valid", 64'(rd_valid), 64'd0);
        chk("R11 ae_bus", 64'(ae_bus), 64'hFF);
        chk("R11 af_bus", 64'(af_bus), 64'h00);
        chk("R11 full q0", 64'(full), 64'd0);
        wr_sel = 3'd3; #1;
        chk("R3 full inactive q3", 64'(full), 64'd1);
        // R1: later pin changes must not matter
        cfg_nq = 4'd8;
        cfg_blks = '0;

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            wr_en = v[81]; wr_sel = v[80:78]; wr_data = v[77:42];
            rd_en = v[41]; rd_sel = v[40:38];
            tick();
            chk("R4 R5 R6 vec valid", 64'(rd_valid), 64'(v[37]));
            if (v[37]) chk("R4 R6 vec data", 64'(rd_data), 64'(v[36:1]));
            chk("R1 R3 vec full", 64'(full), 64'(v[0]));
        end
        wr_en = 1'b0; rd_en = 1'b0; wr_sel = 3'd0; rd_sel = 3'd0;

        // R7: q0 holds 1, others empty
        #1;
        chk("R7 ae initial", 64'(ae_bus), 64'hFF);
        chk("R8 af initial", 64'(af_bus), 64'h00);
        do_write(3'd0, 36'h0A5);
        chk("R7 ae q0 at 2 words", 64'(ae_bus), 64'hFE);

        // R3 R8: fill q1 (256 deep, af offset 4)
        for (int k = 0; k < 251; k++) do_write(3'd1, 36'h100 + 36'(k));
        chk("R8 af q1 at 251", 64'(af_bus[1]), 64'd0);
        chk("R3 full q1 at 251", 64'(full), 64'd0);
        do_write(3'd1, 36'h100 + 36'd251);
        chk("R8 af q1 at 252", 64'(af_bus[1]), 64'd1);
        for (int k = 252; k < 256; k++) do_write(3'd1, 36'h100 + 36'(k));
        wr_sel = 3'd1; #1;
        chk("R3 full q1 at 256", 64'(full), 64'd1);
        do_write(3'd1, 36'hDEAD);
        chk("R3 full after dropped write", 64'(full), 64'd1);

        // R10: drain all 256 in order, extra word absent
        rd_sel = 3'd1;
        tick();
        for (int k = 0; k < 256; k++) begin
            chk("R10 drain valid", 64'(rd_valid), 64'd1);
            chk("R10 drain data", 64'(rd_data), 64'h100 + 64'(k));
            rd_en = 1'b1;
            tick();
        end
        chk("R3 dropped word not stored", 64'(rd_valid), 64'd0);
        rd_en = 1'b0;

        // R10 R6: refill across the wrap, simultaneous read and write
        do_write(3'd1, 36'h0E0);
        do_write(3'd1, 36'h0E1);
        chk("R10 wrap head", 64'(rd_data), 64'h0E0);
        rd_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 36'h0E2;
        tick();
        wr_en = 1'b0;
        chk("R6 same-cycle rw data", 64'(rd_data), 64'h0E1);
        tick();
        chk("R6 order after rw", 64'(rd_data), 64'h0E2);
        tick();
        chk("R10 empty after refill", 64'(rd_valid), 64'd0);
        rd_en = 1'b0;

        // R9: partial reset with differing selects does nothing
        rd_sel = 3'd0;
        do_write(3'd2, 36'h0C9);
        prst = 1'b1; wr_sel = 3'd2; rd_sel = 3'd0;
        tick();
        prst = 1'b0;
        chk("R9 ignored prst valid", 64'(rd_valid), 64'd1);
        chk("R9 ignored prst data", 64'(rd_data), 64'h0A4);
        chk("R9 ignored prst ae q2", 64'(ae_bus[2]), 64'd0);
        rd_sel = 3'd2;
        tick();
        chk("R9 q2 kept word", 64'(rd_data), 64'h0C9);
        // R9: matching selects clear q0 and drop the write
        prst = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; rd_sel = 3'd0; wr_data = 36'hBAD;
        tick();
        prst = 1'b0; wr_en = 1'b0;
        chk("R9 cleared valid", 64'(rd_valid), 64'd0);
        chk("R9 cleared ae q0", 64'(ae_bus[0]), 64'd1);
        do_write(3'd0, 36'h0F1);
        chk("R9 R5 restart data", 64'(rd_data), 64'h0F1);
        chk("R9 R5 restart valid", 64'(rd_valid), 64'd1);

        // R2: default setting via second master reset
        rst_n = 1'b0; cfg_dflt = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        cfg_dflt = 1'b0;
        wr_sel = 3'd7; rd_sel = 3'd7; #1;
        chk("R11 R2 rd_valid after reset", 64'(rd_valid), 64'd0);
        chk("R2 ae all", 64'(ae_bus), 64'hFF);
        chk("R2 full q7 active", 64'(full), 64'd0);
        do_write(3'd7, 36'h0071);
        chk("R2 q7 data", 64'(rd_data), 64'h0071);
        chk("R2 ae q7 at 1", 64'(ae_bus), 64'hFF);
        for (int k = 0; k < 16; k++) do_write(3'd7, 36'h200 + 36'(k));
        chk("R2 ae q7 at 17", 64'(ae_bus), 64'h7F);
        chk("R2 af none", 64'(af_bus), 64'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule